// File: doc/BRIEF.md
# Missing-Code Sweep Controller

This block steps a target code through every output code of an analog-to-digital converter under test and decides whether each code exists. When a code is presented, an external comparator reports a registered "code exists" status. The controller samples that status once per conversion period and counts the samples that come back high. A code passes once enough hits are seen. A code is declared missing when its allowed number of samples runs out before that.

A sweep begins with a start pulse. The hit threshold, the try limit and the conversion period in clock cycles are captured at that moment. The controller then presents codes from zero up to a last code, which is 65534 by default. Each new code comes with a one-cycle load strobe. The controller keeps a count of missing codes and records the first code found missing. When the last code has been judged, it pulses done.

Top module: `code_sweep_ctrl`

## Requirements
- R1: During and right after reset, busy, done, code_load, code_out, miss_count and first_miss_valid are all zero.
- R2: A start pulse while idle does four things at the next clock edge: it captures min_hits, max_tries and sample_period, sets busy, presents code 0 with code_load high, and clears miss_count and first_miss_valid.
- R3: Codes are presented in ascending order, 0, 1, 2 and so on up to LAST_CODE, each exactly once. Each code comes with a code_load pulse that lasts one cycle.
- R4: The status is sampled once every sample_period cycles. The first sample comes sample_period cycles after the code_load edge. A period of 0 behaves as 1.
- R5: A code passes on the sample that brings its hit count to min_hits. If that same sample also reaches max_tries, the pass wins.
- R6: A code whose try count reaches max_tries without enough hits is missing. miss_count rises by one, and the first missing code of the sweep is held in first_miss with first_miss_valid high.
- R7: The hit and try counts start from zero for every newly loaded code.
- R8: After the verdict on LAST_CODE, done is high for exactly one cycle, and busy is already low in that cycle.
- R9: While busy, start pulses and changes to the three setting inputs have no effect on the running sweep.
- R10: miss_count, first_miss and first_miss_valid hold their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| min_hits | input | CNT_W | Hits needed for a code to pass |
| max_tries | input | CNT_W | Samples allowed per code |
| sample_period | input | PER_W | Clock cycles per conversion |
| code_status | input | 1 | Registered "code exists" flag from the comparator |
| code_out | output | CODE_W | Code currently under test |
| code_load | output | 1 | One-cycle strobe when code_out takes a new value |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at sweep end |
| miss_count | output | CODE_W | Number of missing codes in this sweep |
| first_miss | output | CODE_W | First missing code found |
| first_miss_valid | output | 1 | first_miss holds a recorded code |

## Verification
Several properties are checked in every cycle:
- load strobes only while busy, each step advancing the code by exactly one;
- a one-cycle done that never overlaps busy;
- hit and try counts that stay below their thresholds between verdicts;
- sample ticks spaced apart for periods of two or more;
- a miss count that moves only on a miss;
- a first-miss record that stays frozen once set.

The length of each sweep in cycles, the verdict priority when both limits are hit on one sample, the treatment of a zero period, the immunity to start pulses and setting changes mid-sweep, and the retention of results after done can only be shown by the bench's complete sweeps against status patterns with known answers.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;

    // Outcome of the current sample for the code under test
    typedef enum logic [1:0] {
        VERD_WAIT = 2'd0,
        VERD_PASS = 2'd1,
        VERD_MISS = 2'd2
    } verdict_e;

    // Settings captured when a sweep begins
    localparam int DEF_MIN_HITS  = 3;
    localparam int DEF_MAX_TRIES = 30;

    function automatic logic limit_reached(input logic [31:0] count,
                                           input logic [31:0] limit);
        return count >= limit;
    endfunction

endpackage

// File: rtl/csw_pacer.sv
`timescale 1ns/1ps
module csw_pacer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] elapsed_q;
    logic [PER_W:0]   elapsed_plus;

    assign elapsed_plus = {1'b0, elapsed_q} + {{PER_W{1'b0}}, 1'b1};
    assign tick = run && (elapsed_plus >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            elapsed_q <= '0;
        else if (tick)
            elapsed_q <= '0;
        else
            elapsed_q <= elapsed_q + {{(PER_W-1){1'b0}}, 1'b1};
    end

    AST_ONE_SAMPLE_PER_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (tick && period >= PER_W'(2)) |=> !tick); // R4

endmodule

// File: rtl/csw_tally.sv
`timescale 1ns/1ps
module csw_tally
    import csw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic             hit,
    input  logic [CNT_W-1:0] min_hits,
    input  logic [CNT_W-1:0] max_tries,
    output verdict_e         verdict
);
    logic [CNT_W-1:0] hits_q, tries_q;
    logic [CNT_W:0]   hits_nx, tries_nx;

    assign hits_nx  = {1'b0, hits_q}  + {{CNT_W{1'b0}}, hit};
    assign tries_nx = {1'b0, tries_q} + {{CNT_W{1'b0}}, 1'b1};

    always_comb begin
        verdict = VERD_WAIT;
        if (tick) begin
            if (limit_reached(32'(hits_nx), 32'(min_hits)))
                verdict = VERD_PASS;
            else if (limit_reached(32'(tries_nx), 32'(max_tries)))
                verdict = VERD_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hits_q  <= '0;
            tries_q <= '0;
        end else if (tick) begin
            hits_q  <= hits_nx[CNT_W-1:0];
            tries_q <= tries_nx[CNT_W-1:0];
        end
    end

    AST_HITS_BELOW_MIN: assert property (@(posedge clk) disable iff (rst)
        (hits_q != '0) |-> (hits_q < min_hits)); // R5

    AST_TRIES_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (tries_q != '0) |-> (tries_q < max_tries)); // R6

endmodule

// File: rtl/csw_miss_log.sv
`timescale 1ns/1ps
module csw_miss_log #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              record,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] miss_count,
    output logic [CODE_W-1:0] first_code,
    output logic              first_valid
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            miss_count  <= '0;
            first_code  <= '0;
            first_valid <= 1'b0;
        end else if (record) begin
            miss_count <= miss_count + {{(CODE_W-1){1'b0}}, 1'b1};
            if (!first_valid) begin
                first_code  <= code;
                first_valid <= 1'b1;
            end
        end
    end

    AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (first_valid && !clear) |=> $stable(first_code)); // R6

    AST_COUNT_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (!clear && !record) |=> $stable(miss_count)); // R10

endmodule

// File: rtl/code_sweep_ctrl.sv
`timescale 1ns/1ps
module code_sweep_ctrl
    import csw_pkg::*;
#(
    parameter int CODE_W    = 16,
    parameter int LAST_CODE = (1 << CODE_W) - 2,
    parameter int CNT_W     = 8,
    parameter int PER_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  min_hits,
    input  logic [CNT_W-1:0]  max_tries,
    input  logic [PER_W-1:0]  sample_period,
    input  logic              code_status,
    output logic [CODE_W-1:0] code_out,
    output logic              code_load,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] miss_count,
    output logic [CODE_W-1:0] first_miss,
    output logic              first_miss_valid
);
    localparam logic [CODE_W-1:0] LAST_C = CODE_W'(LAST_CODE);

    logic              busy_q, load_q, done_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  min_q, max_q;
    logic [PER_W-1:0]  per_q;

    logic     accept, advance, at_last, restart, tick;
    verdict_e verdict;

    assign accept  = start && !busy_q;
    assign advance = busy_q && (verdict != VERD_WAIT);
    assign at_last = (code_q == LAST_C);
    assign restart = accept || advance;

    csw_pacer #(.PER_W(PER_W)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy_q),
        .restart (restart),
        .period  (per_q),
        .tick    (tick)
    );

    csw_tally #(.CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .clear     (restart),
        .tick      (tick),
        .hit       (code_status),
        .min_hits  (min_q),
        .max_tries (max_q),
        .verdict   (verdict)
    );

    csw_miss_log #(.CODE_W(CODE_W)) u_log (
        .clk         (clk),
        .rst         (rst),
        .clear       (accept),
        .record      (busy_q && (verdict == VERD_MISS)),
        .code        (code_q),
        .miss_count  (miss_count),
        .first_code  (first_miss),
        .first_valid (first_miss_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            load_q <= 1'b0;
            done_q <= 1'b0;
            code_q <= '0;
            min_q  <= CNT_W'(DEF_MIN_HITS);
            max_q  <= CNT_W'(DEF_MAX_TRIES);
            per_q  <= '0;
        end else begin
            load_q <= 1'b0;
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                code_q <= '0;
                load_q <= 1'b1;
                min_q  <= min_hits;
                max_q  <= max_tries;
                per_q  <= sample_period;
            end else if (advance) begin
                if (at_last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    code_q <= code_q + {{(CODE_W-1){1'b0}}, 1'b1};
                    load_q <= 1'b1;
                end
            end
        end
    end

    assign code_out  = code_q;
    assign code_load = load_q;
    assign busy      = busy_q;
    assign done      = done_q;

    AST_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        code_load |-> busy); // R3

    AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
        (code_load && $past(busy_q)) |-> (code_q - $past(code_q) == CODE_W'(1))); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_RELEASES_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        accept |=> (code_q == '0 && load_q && miss_count == '0 && !first_miss_valid)); // R2

endmodule

// File: tb/tb_code_sweep_ctrl.sv
`timescale 1ns/1ps
module tb_code_sweep_ctrl;
    localparam int CW    = 16;
    localparam int LAST  = 7;
    localparam int CNT_W = 8;
    localparam int PER_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] min_hits = '0;
    logic [CNT_W-1:0] max_tries = '0;
    logic [PER_W-1:0] per = '0;
    logic             status;
    int               mode = 0;

    logic [CW-1:0] code_out, miss_count, first_miss;
    logic          code_load, busy, done, first_miss_valid;

    always #2 clk = ~clk;

    // mode 0: every code exists; mode 1: codes 3 and 6 never hit; mode 2: only odd codes hit
    assign status = (mode == 0) ? 1'b1 :
                    (mode == 1) ? !(code_out == CW'(3) || code_out == CW'(6)) :
                    code_out[0];

    code_sweep_ctrl #(.CODE_W(CW), .LAST_CODE(LAST), .CNT_W(CNT_W), .PER_W(PER_W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .min_hits(min_hits), .max_tries(max_tries), .sample_period(per),
        .code_status(status),
        .code_out(code_out), .code_load(code_load), .busy(busy), .done(done),
        .miss_count(miss_count), .first_miss(first_miss), .first_miss_valid(first_miss_valid)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode, min_hits, max_tries, period, cycles start->done, misses, first miss (-1: none)
    localparam int NV = 5;
    localparam int VEC[NV][7] = '{
        '{0, 3, 5, 2, 48, 0, -1},
        '{1, 2, 4, 3, 60, 2,  3},
        '{2, 1, 2, 1, 12, 4,  0},
        '{0, 4, 4, 1, 32, 0, -1},
        '{1, 1, 1, 0,  8, 2,  3}
    };

    task automatic sweep(input int m, input int mn, input int mx, input int p,
                         input int ex_cyc, input int ex_miss, input int ex_first,
                         input bit disturb);
        int  n = 0;
        int  loads = 1;
        int  bad = 0;
        int  nextc = 1;
        bit  seen = 1'b0;
        mode      = m;
        min_hits  = CNT_W'(mn);
        max_tries = CNT_W'(mx);
        per       = PER_W'(p);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && code_load && code_out == '0 && miss_count == '0 && !first_miss_valid,
            "R2 start presents code 0", int'(code_out), 0);
        while (!seen && n < 5000) begin
            @(negedge clk);
            n++;
            if (disturb && n == 10) begin
                start = 1'b1; min_hits = CNT_W'(1); per = PER_W'(1);
            end
            if (disturb && n == 11) start = 1'b0;
            if (code_load) begin
                loads++;
                if (int'(code_out) != nextc) bad++;
                nextc++;
            end
            if (done) seen = 1'b1;
        end
        chk(seen && n == ex_cyc, disturb ? "R9 sweep length unaffected" :
            "R4 R5 R7 sweep length", n, ex_cyc);
        chk(loads == LAST + 1 && bad == 0, "R3 ascending loads", loads - bad, LAST + 1);
        chk(!busy, "R8 busy low with done", int'(busy), 0);
        chk(int'(miss_count) == ex_miss, "R6 miss count", int'(miss_count), ex_miss);
        chk(first_miss_valid == (ex_first >= 0) && (ex_first < 0 || int'(first_miss) == ex_first),
            "R6 first missing code", first_miss_valid ? int'(first_miss) : -1, ex_first);
        @(negedge clk);
        chk(!done, "R8 done lasts one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !code_load && code_out == '0 && miss_count == '0 && !first_miss_valid,
            "R1 reset state", int'(busy) + int'(done) + int'(code_load), 0);

        for (int i = 0; i < NV; i++)
            sweep(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6], 1'b0);

        // R9: start pulse and setting changes in mid-sweep
        sweep(1, 2, 4, 3, 60, 2, 3, 1'b1);

        // R10: results held after done until the next start
        repeat (5) @(negedge clk);
        chk(int'(miss_count) == 2, "R10 count held after done", int'(miss_count), 2);
        chk(first_miss_valid && int'(first_miss) == 3, "R10 first miss held", int'(first_miss), 3);
        sweep(0, 1, 1, 1, 8, 0, -1, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule